// File: doc/BRIEF.md
# Two-Direction Latched/Registered Word Transceiver

This block moves an 18-bit word (16 data bits and one parity bit per byte) between two ports, A and B. Each direction has its own storage stage and its own latch enable, port clock and active-low output enable, so the A-to-B and B-to-A paths run independently. A direction can pass its input straight through while the latch enable is high. It can freeze the word it last saw when the latch enable drops. With the latch enable low, it can take a new word on a rising edge of its port clock.

The block runs inside one system clock domain. Each port clock is sampled there and edge-detected, so a capture happens only in the system cycle in which a low-to-high change of that port clock is seen. The block has no tristate pins. Each output is a data bus plus a drive flag, and while the flag is low the bus reads as zero. Parity bits are stored and forwarded as data and are neither generated nor checked here.

Top module: `dual_dir_transceiver`

## Requirements
- R1: A synchronous reset clears both stored words to zero; after reset, with latch enables low, output enables low and no port clock edge, both outputs read zero with their drive flags high.
- R2: While a direction's active-low output enable is high, its drive flag is 0 and its output word (data and parity) reads all zeros, whatever the latch enable, port clock and input are doing.
- R3: A direction's drive flag is the inverse of its active-low output enable in every cycle.
- R4: With output enable low and latch enable high, the output equals the input in the same system cycle, with no clock edge needed.
- R5: With latch enable low, a system cycle in which the port clock is sampled high after being sampled low stores that cycle's input, and the output shows it from the next system cycle on.
- R6: With latch enable low and the port clock sampled steady, high or low, the output keeps its stored word even when the input changes.
- R7: When the latch enable falls and no port clock rise is seen in that cycle, the stored word is the input of the last cycle in which the latch enable was high. This also holds when the port clock is high at that moment.
- R8: The A-to-B path (driving port B) uses only its own latch enable, port clock and output enable, and the B-to-A path (driving port A) uses only its own set. Activity on one direction never changes the other direction's stored word or drive flag.
- R9: All 18 bits travel together: bits 15:0 carry data, and parity bit 0 (for data byte 7:0) and parity bit 1 (for data byte 15:8) are stored and forwarded on the parity port unchanged.
- R10: A capture or latch that happens while the output enable is high still updates the stored word, and that word appears as soon as the output enable goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_data_i | input | 16 | Data arriving at port A (source for A-to-B) |
| a_par_i | input | 2 | Byte parity arriving at port A |
| b_data_i | input | 16 | Data arriving at port B (source for B-to-A) |
| b_par_i | input | 2 | Byte parity arriving at port B |
| ab_le | input | 1 | A-to-B latch enable, high = transparent |
| ab_pclk | input | 1 | A-to-B port clock, captures on rising transition |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_le | input | 1 | B-to-A latch enable, high = transparent |
| ba_pclk | input | 1 | B-to-A port clock, captures on rising transition |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| b_data_o | output | 16 | Data presented on port B |
| b_par_o | output | 2 | Byte parity presented on port B |
| b_drive | output | 1 | Port B drive flag |
| a_data_o | output | 16 | Data presented on port A |
| a_par_o | output | 2 | Byte parity presented on port A |
| a_drive | output | 1 | Port A drive flag |

## Verification
The latch enable falling and a port clock rise can land in the same system cycle. In that case the storage stage must decide between keeping the last transparent word and taking the word on the input. The bench sets this up by lowering the latch enable and raising the port clock at the same falling system-clock edge, with a new input word that differs from the last transparent one. It expects the new word on the output after the next system edge. The same scenario is run with both directions active at once, and each direction's result is checked against its own input.

// File: rtl/dual_dir_transceiver.sv
module dual_dir_transceiver #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] a_data_i,
  input  logic [DATA_W/BYTE_W-1:0] a_par_i,
  input  logic [DATA_W-1:0] b_data_i,
  input  logic [DATA_W/BYTE_W-1:0] b_par_i,
  input  logic              ab_le,
  input  logic              ab_pclk,
  input  logic              ab_oe_n,
  input  logic              ba_le,
  input  logic              ba_pclk,
  input  logic              ba_oe_n,
  output logic [DATA_W-1:0] b_data_o,
  output logic [DATA_W/BYTE_W-1:0] b_par_o,
  output logic              b_drive,
  output logic [DATA_W-1:0] a_data_o,
  output logic [DATA_W/BYTE_W-1:0] a_par_o,
  output logic              a_drive
);
  localparam int PAR_W  = DATA_W / BYTE_W;
  localparam int WORD_W = DATA_W + PAR_W;

  logic [1:0][WORD_W-1:0] src_w, dst_w;
  logic [1:0] le_w, pclk_w, oe_n_w;

  assign src_w[0] = {a_par_i, a_data_i};
  assign src_w[1] = {b_par_i, b_data_i};
  assign le_w     = {ba_le, ab_le};
  assign pclk_w   = {ba_pclk, ab_pclk};
  assign oe_n_w   = {ba_oe_n, ab_oe_n};

  for (genvar g = 0; g < 2; g++) begin : g_dir
    logic [WORD_W-1:0] held;
    logic              pclk_q;
    logic              pclk_rise;

    assign pclk_rise = pclk_w[g] & ~pclk_q;

    always_ff @(posedge clk) begin
      pclk_q <= pclk_w[g];
      if (rst)
        held <= '0;
      else if (le_w[g] | pclk_rise)
        held <= src_w[g];
    end

    assign dst_w[g] = oe_n_w[g] ? '0 : (le_w[g] ? src_w[g] : held);
  end

  assign {b_par_o, b_data_o} = dst_w[0];
  assign {a_par_o, a_data_o} = dst_w[1];
  assign b_drive = ~ab_oe_n;
  assign a_drive = ~ba_oe_n;
endmodule

// File: rtl/dual_dir_transceiver_chk.sv
module dual_dir_transceiver_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic         le,
  input logic         pclk,
  input logic         oe_n,
  input logic [W-1:0] din,
  input logic [W-1:0] dout,
  input logic         drive
);
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> (!drive && dout == '0)); // R2

  AST_TRANSPARENT: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && le) |-> (dout == din)); // R4

  AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    $rose(pclk) |=> (oe_n || le || dout == $past(din))); // R5

  AST_STEADY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!le && !oe_n && !$rose(pclk)) |=> (oe_n || le || $stable(dout))); // R6

  AST_LATCH_CLOSE: assert property (@(posedge clk) disable iff (rst)
    le |=> (oe_n || le || dout == $past(din))); // R7
endmodule

bind dual_dir_transceiver dual_dir_transceiver_chk #(.W(WORD_W)) u_chk_ab (
  .clk(clk), .rst(rst), .le(ab_le), .pclk(ab_pclk), .oe_n(ab_oe_n),
  .din({a_par_i, a_data_i}), .dout({b_par_o, b_data_o}), .drive(b_drive));

bind dual_dir_transceiver dual_dir_transceiver_chk #(.W(WORD_W)) u_chk_ba (
  .clk(clk), .rst(rst), .le(ba_le), .pclk(ba_pclk), .oe_n(ba_oe_n),
  .din({b_par_i, b_data_i}), .dout({a_par_o, a_data_o}), .drive(a_drive));

// File: tb/dual_dir_transceiver_test.sv
`timescale 1ns/1ps
module dual_dir_transceiver_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [17:0] a_in = '0, b_in = '0;
  logic ab_le = 0, ab_pclk = 0, ab_oe_n = 0;
  logic ba_le = 0, ba_pclk = 0, ba_oe_n = 0;
  logic [15:0] b_data_o, a_data_o;
  logic [1:0]  b_par_o, a_par_o;
  logic b_drive, a_drive;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dual_dir_transceiver uut (
    .clk(clk), .rst(rst),
    .a_data_i(a_in[15:0]), .a_par_i(a_in[17:16]),
    .b_data_i(b_in[15:0]), .b_par_i(b_in[17:16]),
    .ab_le(ab_le), .ab_pclk(ab_pclk), .ab_oe_n(ab_oe_n),
    .ba_le(ba_le), .ba_pclk(ba_pclk), .ba_oe_n(ba_oe_n),
    .b_data_o(b_data_o), .b_par_o(b_par_o), .b_drive(b_drive),
    .a_data_o(a_data_o), .a_par_o(a_par_o), .a_drive(a_drive));

  wire [17:0] b_out = {b_par_o, b_data_o};
  wire [17:0] a_out = {a_par_o, a_data_o};

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic at_neg();
    @(negedge clk);
  endtask

  task automatic t_reset();
    at_neg(); rst = 1; a_in = 18'h2ABCD; b_in = 18'h15555;
    ab_le = 0; ba_le = 0; ab_pclk = 0; ba_pclk = 0; ab_oe_n = 0; ba_oe_n = 0;
    tick(); tick(); tick();
    at_neg(); rst = 0;
    tick();
    chk("R1 port B after reset", b_out, 18'h0);
    chk("R1 port A after reset", a_out, 18'h0);
    chk("R1 drive flags after reset", {16'h0, b_drive, a_drive}, 18'h3);
  endtask

  task automatic t_oe();
    at_neg(); ab_oe_n = 1; ab_le = 1; a_in = 18'h3F00F;
    #1;
    chk("R2 disabled port B word", b_out, 18'h0);
    chk("R3 drive flag low while disabled", {17'h0, b_drive}, 18'h0);
    chk("R8 port A drive unaffected", {17'h0, a_drive}, 18'h1);
    at_neg(); ab_oe_n = 0;
    #1;
    chk("R3 drive flag high when enabled", {17'h0, b_drive}, 18'h1);
  endtask

  task automatic t_transparent();
    at_neg(); ab_le = 1; a_in = 18'h11234;
    #1; chk("R4 transparent word 1", b_out, 18'h11234);
    at_neg(); a_in = 18'h2FEDC;
    #1; chk("R4 transparent word 2", b_out, 18'h2FEDC);
  endtask

  task automatic t_capture_hold();
    at_neg(); ab_le = 1; ab_pclk = 0; a_in = 18'h00111;
    tick();
    at_neg(); ab_le = 0; a_in = 18'h00222;
    tick();
    chk("R6 clock low, input change ignored", b_out, 18'h00111);
    at_neg(); ab_pclk = 1; a_in = 18'h3A5A5;
    tick();
    chk("R5 rising port clock captures", b_out, 18'h3A5A5);
    at_neg(); a_in = 18'h05A5A;
    tick(); tick();
    chk("R6 clock held high, no capture", b_out, 18'h3A5A5);
    at_neg(); ab_pclk = 0; a_in = 18'h1C3C3;
    tick();
    chk("R6 falling port clock ignored", b_out, 18'h3A5A5);
  endtask

  task automatic t_latch_close();
    at_neg(); ab_pclk = 1; ab_le = 1; a_in = 18'h2BEEF;
    tick();
    at_neg(); ab_le = 0; a_in = 18'h10F0F;
    tick();
    chk("R7 latch closed with clock high", b_out, 18'h2BEEF);
    at_neg(); a_in = 18'h3FFFF;
    tick();
    chk("R7 latched word kept", b_out, 18'h2BEEF);
  endtask

  task automatic t_same_cycle();
    at_neg(); ab_pclk = 0; ba_pclk = 0; ab_le = 1; ba_le = 1;
    a_in = 18'h01111; b_in = 18'h02222;
    tick();
    at_neg(); ab_le = 0; ba_le = 0; ab_pclk = 1; ba_pclk = 1;
    a_in = 18'h1AAAA; b_in = 18'h25555;
    tick();
    chk("R5 edge with latch fall, port B", b_out, 18'h1AAAA);
    chk("R5 edge with latch fall, port A", a_out, 18'h25555);
  endtask

  task automatic t_parity();
    at_neg(); ab_le = 1; a_in = {2'b10, 16'h00FF};
    #1;
    chk("R9 parity bits forwarded", {16'h0, b_par_o}, 18'h2);
    chk("R9 data bits forwarded", {2'b00, b_data_o}, 18'h000FF);
    at_neg(); a_in = {2'b01, 16'hFF00};
    #1;
    chk("R9 parity bits swapped pattern", {16'h0, b_par_o}, 18'h1);
  endtask

  task automatic t_disabled_capture();
    at_neg(); ab_le = 0; ab_pclk = 0; ab_oe_n = 1; a_in = 18'h0CAFE;
    tick();
    at_neg(); ab_pclk = 1;
    tick();
    chk("R2 disabled during capture", b_out, 18'h0);
    at_neg(); ab_oe_n = 0; a_in = 18'h00000;
    #1;
    chk("R10 word captured while disabled", b_out, 18'h0CAFE);
  endtask

  task automatic t_independent();
    at_neg(); ab_le = 0; ab_pclk = 0; a_in = 18'h12345;
    ba_le = 0; ba_pclk = 0; b_in = 18'h3ABCD;
    tick();
    at_neg(); ab_pclk = 1;
    tick();
    chk("R8 port B captured", b_out, 18'h12345);
    at_neg(); ba_pclk = 1; ba_le = 1; ba_oe_n = 1; a_in = 18'h00001;
    tick();
    chk("R8 port B unaffected by other direction", b_out, 18'h12345);
    chk("R8 port B drive unaffected", {17'h0, b_drive}, 18'h1);
    at_neg(); ba_le = 0; ba_oe_n = 0;
    #1;
    chk("R8 port A holds its own word", a_out, 18'h3ABCD);
  endtask

  initial begin
    t_reset();
    t_oe();
    t_transparent();
    t_capture_hold();
    t_latch_close();
    t_same_cycle();
    t_parity();
    t_disabled_capture();
    t_independent();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule